// File: doc/BRIEF.md
# Doorbell Outstanding-Request Tracker

This block keeps track of outbound doorbell requests from the moment they are sent until the far device answers them. The sender presents each doorbell with an 8-bit transaction ID and a 16-bit payload. The tracker records it in a 16-slot pending table, using the low four bits of the ID to pick the slot. Incoming response packets are matched against the table by transaction ID. A matched response retires the slot with the status it carries. Every slot ages against a reload value that software programs. A slot that receives no answer before its counter runs out is retired as timed out.

All retired requests, whether they were answered or timed out, are queued in one completion FIFO. Software drains that FIFO through a 32-bit register port. The same port exposes two sticky error flags: one for a response that matches nothing, and one for a request that timed out.

Top module: `doorbell_tracker`

## Requirements
- R1: A request is accepted when `reqValid` and `reqReady` are both high at a clock edge. `reqReady` is low while the slot selected by `reqTid[3:0]` still holds a request.
- R2: The block holds at most FIFO_DEPTH (16) requests in total, counting pending slots and unread completion words together. When that total is reached, `reqReady` is low even if the slot is free. It goes high again after one completion word is read.
- R3: A response whose `rspTid` equals the full 8-bit ID held in slot `rspTid[3:0]` retires that slot. The status it records is 00 for done, 01 for retry and 10 for error. An input status of 11 is recorded as 10.
- R4: A response that matches no pending request sets the unexpected flag (bit 0 of register word 1) and leaves the table unchanged.
- R5: Register word 0, bits 23:0, holds the timeout reload value. It resets to 0xFFFFFF. A slot loads this value when it accepts a request, and its counter decrements once every TICK_DIV (4) cycles. A slot whose counter is zero retires with status 11.
- R6: A timeout completion sets the sticky timeout flag, which is bit 1 of register word 1.
- R7: If a slot gets its response in the same cycle that it expires, the response status wins and the timeout flag is not set.
- R8: At most one completion is queued per cycle. A matched response goes first. The lowest-numbered expired slot follows in a later cycle, so the FIFO keeps that order.
- R9: Reading register word 2 pops one completion word laid out as {valid[31], 5'b0, status[25:24], ID[23:16], payload[15:0]}. Reading it while the FIFO is empty returns zero. Read data appears on `regRdata` one cycle after `regRead`.
- R10: Writing a one to bit 0 or bit 1 of register word 1 clears the matching flag only. Writing a zero leaves a flag as it is.
- R11: After reset the table is empty, `reqReady` is high, both flags are clear, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Outbound doorbell presented |
| reqReady | output | 1 | Tracker can take the presented doorbell |
| reqTid | input | 8 | Transaction ID of the outbound doorbell |
| reqPayload | input | 16 | Payload of the outbound doorbell |
| rspValid | input | 1 | Response packet present this cycle |
| rspTid | input | 8 | Transaction ID carried by the response |
| rspStatus | input | 2 | Response kind: 00 done, 01 retry, 10 error |
| regAddr | input | 2 | Register word index |
| regWrite | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRead | input | 1 | Register read strobe |
| regRdata | output | 32 | Register read data, valid one cycle after the read |

## Verification
A response can arrive in the same cycle that the slot it targets, or another slot, reaches a zero count. The bench sets the reload value to zero, so a slot expires in the very cycle after it is accepted. It then drives the response in exactly that cycle. The bench checks that the completion carries the response status and that no timeout flag appears. In a second case, a long-lived slot is answered while a freshly accepted zero-reload slot expires. The bench checks that the answered word is queued ahead of the timed-out one.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TID_W   = 8;
  localparam int PAY_W   = 16;
  localparam int TMO_W   = 24;
  localparam int WORD_W  = 2 + TID_W + PAY_W;

  localparam logic [1:0] ADDR_RELOAD = 2'd0;
  localparam logic [1:0] ADDR_FLAGS  = 2'd1;
  localparam logic [1:0] ADDR_CPL    = 2'd2;

  typedef enum logic [1:0] {
    ST_DONE    = 2'b00,
    ST_RETRY   = 2'b01,
    ST_ERROR   = 2'b10,
    ST_TIMEOUT = 2'b11
  } cplStatus_t;

  typedef struct packed {
    logic             alloc;
    logic             retire;
    logic [IDX_W-1:0] retireIdx;
    logic             push;
    cplStatus_t       pushStatus;
    logic             pop;
    logic             tick;
  } strobe_t;
endpackage

// File: rtl/dbt_data.sv
module dbt_data
  import dbt_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int PTR_W = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [TID_W-1:0]   reqTid,
  input  logic [PAY_W-1:0]   reqPayload,
  input  logic [TMO_W-1:0]   reloadVal,
  input  logic [IDX_W-1:0]   rspIdx,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] expiredVec,
  output logic [TID_W-1:0]   tidAt,
  output logic               fifoEmpty,
  output logic               roomOk,
  output logic [WORD_W-1:0]  cplWord,
  output logic [CNT_W-1:0]   cplCount
);
  logic [TID_W-1:0]  entTid [ENTRIES];
  logic [PAY_W-1:0]  entPay [ENTRIES];
  logic [TMO_W-1:0]  entCnt [ENTRIES];
  logic [ENTRIES-1:0] entValid;
  logic [IDX_W-1:0]  allocIdx;

  assign allocIdx = reqTid[IDX_W-1:0];

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entCnt[i]   <= '0;
        entTid[i]   <= '0;
        entPay[i]   <= '0;
      end else if (stb.alloc && allocIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b1;
        entCnt[i]   <= reloadVal;
        entTid[i]   <= reqTid;
        entPay[i]   <= reqPayload;
      end else if (stb.retire && stb.retireIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b0;
      end else if (stb.tick && entValid[i] && entCnt[i] != '0) begin
        entCnt[i] <= entCnt[i] - 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
      assign validVec[g]   = entValid[g];
      assign expiredVec[g] = entValid[g] && (entCnt[g] == '0);
    end
  endgenerate

  assign tidAt = entTid[rspIdx];

  // completion queue
  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  inUse;
  logic [WORD_W-1:0] pushWord;

  assign pushWord = {stb.pushStatus, entTid[stb.retireIdx], entPay[stb.retireIdx]};

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      cplCount <= '0;
      inUse    <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (stb.push && !stb.pop)      cplCount <= cplCount + 1'b1;
      else if (stb.pop && !stb.push) cplCount <= cplCount - 1'b1;
      if (stb.alloc && !stb.pop)      inUse <= inUse + 1'b1;
      else if (stb.pop && !stb.alloc) inUse <= inUse - 1'b1;
    end
  end

  assign fifoEmpty = (cplCount == '0);
  assign roomOk    = (inUse < CNT_W'(FIFO_DEPTH));
  assign cplWord   = mem[rdPtr];
endmodule

// File: rtl/dbt_ctrl.sv
module dbt_ctrl
  import dbt_pkg::*;
#(
  parameter int TICK_DIV = 4,
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [IDX_W-1:0]   reqIdx,
  output logic               reqReady,
  input  logic               rspValid,
  input  logic [TID_W-1:0]   rspTid,
  input  logic [1:0]         rspStatus,
  input  logic [1:0]         regAddr,
  input  logic               regWrite,
  input  logic [31:0]        regWdata,
  input  logic               regRead,
  output logic [31:0]        regRdata,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] expiredVec,
  input  logic [TID_W-1:0]   tidAt,
  input  logic               fifoEmpty,
  input  logic               roomOk,
  input  logic [WORD_W-1:0]  cplWord,
  output strobe_t            stb,
  output logic [TMO_W-1:0]   reloadVal
);
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             rspHit, anyExp;
  logic [IDX_W-1:0] rspIdx, expIdx;
  logic             unexpFlag, tmoFlag;
  logic             flagWr;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  assign rspIdx   = rspTid[IDX_W-1:0];
  assign rspHit   = rspValid && validVec[rspIdx] && (tidAt == rspTid);
  assign anyExp   = |expiredVec;
  assign reqReady = !validVec[reqIdx] && roomOk;

  always_comb begin
    expIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (expiredVec[i]) expIdx = IDX_W'(i);
  end

  always_comb begin
    stb       = '0;
    stb.tick  = tick;
    stb.alloc = reqValid && reqReady;
    stb.pop   = regRead && (regAddr == ADDR_CPL) && !fifoEmpty;
    if (rspHit) begin
      stb.retire     = 1'b1;
      stb.retireIdx  = rspIdx;
      stb.push       = 1'b1;
      stb.pushStatus = (rspStatus == 2'b11) ? ST_ERROR : cplStatus_t'(rspStatus);
    end else if (anyExp) begin
      stb.retire     = 1'b1;
      stb.retireIdx  = expIdx;
      stb.push       = 1'b1;
      stb.pushStatus = ST_TIMEOUT;
    end
  end

  assign flagWr = regWrite && (regAddr == ADDR_FLAGS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unexpFlag <= 1'b0;
      tmoFlag   <= 1'b0;
      reloadVal <= '1;
      regRdata  <= '0;
    end else begin
      unexpFlag <= (rspValid && !rspHit) || (unexpFlag && !(flagWr && regWdata[0]));
      tmoFlag   <= (stb.push && stb.pushStatus == ST_TIMEOUT) ||
                   (tmoFlag && !(flagWr && regWdata[1]));
      if (regWrite && regAddr == ADDR_RELOAD) reloadVal <= regWdata[TMO_W-1:0];
      if (regRead) begin
        unique case (regAddr)
          ADDR_RELOAD: regRdata <= 32'(reloadVal);
          ADDR_FLAGS:  regRdata <= {30'b0, tmoFlag, unexpFlag};
          ADDR_CPL:    regRdata <= fifoEmpty ? '0 : {1'b1, (31 - WORD_W)'(0), cplWord};
          default:     regRdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/doorbell_tracker.sv
module doorbell_tracker
  import dbt_pkg::*;
#(
  parameter int TICK_DIV   = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [7:0]  reqTid,
  input  logic [15:0] reqPayload,
  input  logic        rspValid,
  input  logic [7:0]  rspTid,
  input  logic [1:0]  rspStatus,
  input  logic [1:0]  regAddr,
  input  logic        regWrite,
  input  logic [31:0] regWdata,
  input  logic        regRead,
  output logic [31:0] regRdata
);
  strobe_t            stb;
  logic [ENTRIES-1:0] validVec, expiredVec;
  logic [TID_W-1:0]   tidAt;
  logic               fifoEmpty, roomOk;
  logic [WORD_W-1:0]  cplWord;
  logic [CNT_W-1:0]   cplCount;
  logic [TMO_W-1:0]   reloadVal;

  dbt_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIdx(reqTid[IDX_W-1:0]),
    .reqReady(reqReady), .rspValid(rspValid), .rspTid(rspTid), .rspStatus(rspStatus),
    .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata), .regRead(regRead),
    .regRdata(regRdata), .validVec(validVec), .expiredVec(expiredVec), .tidAt(tidAt),
    .fifoEmpty(fifoEmpty), .roomOk(roomOk), .cplWord(cplWord), .stb(stb),
    .reloadVal(reloadVal)
  );

  dbt_data #(.FIFO_DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .reqTid(reqTid), .reqPayload(reqPayload),
    .reloadVal(reloadVal), .rspIdx(rspTid[IDX_W-1:0]), .validVec(validVec),
    .expiredVec(expiredVec), .tidAt(tidAt), .fifoEmpty(fifoEmpty), .roomOk(roomOk),
    .cplWord(cplWord), .cplCount(cplCount)
  );
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [7:0]  reqTid,
  input logic        rspValid,
  input logic [7:0]  rspTid,
  input logic [15:0] validVec,
  input logic [7:0]  tidAt,
  input logic        fifoEmpty,
  input logic [CNT_W-1:0] cplCount,
  input logic        regRead,
  input logic [1:0]  regAddr,
  input logic [31:0] regRdata
);
  // R1
  busy_slot_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |-> !validVec[reqTid[3:0]]);
  // R1
  accept_fills_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> validVec[$past(reqTid[3:0])]);
  // R2
  credit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cplCount) + $countones(validVec)) <= FIFO_DEPTH);
  // R3
  match_queues_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && validVec[rspTid[3:0]] && tidAt == rspTid |=> !fifoEmpty);
  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRead && regAddr == 2'd2 && fifoEmpty |=> regRdata == 32'd0);
endmodule

bind doorbell_tracker dbt_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqTid(reqTid),
  .rspValid(rspValid), .rspTid(rspTid), .validVec(validVec), .tidAt(tidAt),
  .fifoEmpty(fifoEmpty), .cplCount(cplCount), .regRead(regRead), .regAddr(regAddr),
  .regRdata(regRdata)
);

// File: tb/doorbell_tracker_bench.sv
module doorbell_tracker_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, rspValid = 0, regWrite = 0, regRead = 0;
  logic reqReady;
  logic [7:0] reqTid = 0, rspTid = 0;
  logic [15:0] reqPayload = 0;
  logic [1:0] rspStatus = 0, regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  int nChecks = 0, nFails = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  doorbell_tracker u_doorbell_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqTid(reqTid),
    .reqPayload(reqPayload), .rspValid(rspValid), .rspTid(rspTid), .rspStatus(rspStatus),
    .regAddr(regAddr), .regWrite(regWrite), .regWdata(regWdata), .regRead(regRead),
    .regRdata(regRdata)
  );

  // {reqTid, payload, rspTid, rspStatus, expected completion word, expected flags}
  localparam logic [67:0] VECS [5] = '{
    {8'h01, 16'h1234, 8'h01, 2'b00, 32'h8001_1234, 2'b00},
    {8'h42, 16'hBEEF, 8'h42, 2'b01, 32'h8142_BEEF, 2'b00},
    {8'h9C, 16'h0F0F, 8'h9C, 2'b10, 32'h829C_0F0F, 2'b00},
    {8'h35, 16'hAAAA, 8'h35, 2'b11, 32'h8235_AAAA, 2'b00},
    {8'h13, 16'h5555, 8'h23, 2'b00, 32'h0000_0000, 2'b01}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic sendReq(input logic [7:0] t, input logic [15:0] p);
    reqValid = 1; reqTid = t; reqPayload = p;
    @(negedge clk); reqValid = 0;
  endtask

  task automatic sendRsp(input logic [7:0] t, input logic [1:0] s);
    rspValid = 1; rspTid = t; rspStatus = s;
    @(negedge clk); rspValid = 0;
  endtask

  task automatic regWr(input logic [1:0] a, input logic [31:0] d);
    regWrite = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrite = 0;
  endtask

  task automatic regRd(input logic [1:0] a, output logic [31:0] d);
    regRead = 1; regAddr = a;
    @(negedge clk); regRead = 0; d = regRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    #1 check("R11 ready", 32'(reqReady), 32'd1);
    regRd(2'd1, rd); check("R11 flags", rd, 32'd0);
    regRd(2'd2, rd); check("R11 fifo empty", rd, 32'd0);
    regRd(2'd0, rd); check("R5 reload reset", rd, 32'h00FF_FFFF);
    regWr(2'd0, 32'd1000);
    regRd(2'd0, rd); check("R5 reload readback", rd, 32'd1000);

    // table walk: R3, R4, R9
    for (int i = 0; i < 5; i++) begin
      sendReq(VECS[i][67:60], VECS[i][59:44]);
      sendRsp(VECS[i][43:36], VECS[i][35:34]);
      regRd(2'd2, rd); check($sformatf("R3 vec%0d word", i), rd, VECS[i][33:2]);
      regRd(2'd1, rd); check($sformatf("R4 vec%0d flags", i), rd, 32'(VECS[i][1:0]));
      if (VECS[i][33:2] == 32'd0) begin
        sendRsp(VECS[i][67:60], 2'b00);
        regRd(2'd2, rd);
        check("R4 entry kept", rd, {1'b1, 7'd0, VECS[i][67:60], VECS[i][59:44]});
        regWr(2'd1, 32'd3);
      end
    end

    // R1 busy slot refusal
    sendReq(8'h07, 16'h7777);
    reqTid = 8'h17; #1 check("R1 busy slot", 32'(reqReady), 32'd0);
    reqTid = 8'h08; #1 check("R1 free slot", 32'(reqReady), 32'd1);
    @(negedge clk);
    sendRsp(8'h07, 2'b00);
    regRd(2'd2, rd); check("R1 drain", rd, 32'h8007_7777);

    // R2 credit limit
    for (int i = 0; i < 16; i++) begin
      sendReq(8'(i), 16'(16'hC000 + i));
      sendRsp(8'(i), 2'b00);
    end
    reqTid = 8'h00; #1 check("R2 full credit", 32'(reqReady), 32'd0);
    @(negedge clk);
    regRd(2'd2, rd); check("R2 first pop", rd, 32'h8000_C000);
    #1 check("R2 credit back", 32'(reqReady), 32'd1);
    @(negedge clk);
    for (int i = 1; i < 16; i++) regRd(2'd2, rd);
    check("R2 last pop", rd, 32'h800F_C00F);

    // R5, R6 timeout
    regWr(2'd0, 32'd3);
    sendReq(8'h0B, 16'hBBBB);
    repeat (4) @(negedge clk);
    regRd(2'd2, rd); check("R5 not yet", rd, 32'd0);
    repeat (20) @(negedge clk);
    regRd(2'd2, rd); check("R5 timed out", rd, 32'h830B_BBBB);
    regRd(2'd1, rd); check("R6 timeout flag", rd, 32'd2);
    regWr(2'd1, 32'd2);

    // R7 response in the expiry cycle
    regWr(2'd0, 32'd0);
    sendReq(8'h06, 16'h6666);
    sendRsp(8'h06, 2'b01);
    regRd(2'd2, rd); check("R7 response wins", rd, 32'h8106_6666);
    regRd(2'd1, rd); check("R7 no timeout flag", rd, 32'd0);

    // R8 ordering of a response and another slot's expiry
    regWr(2'd0, 32'd1000);
    sendReq(8'h0C, 16'hC0C0);
    regWr(2'd0, 32'd0);
    sendReq(8'h0A, 16'hA0A0);
    sendRsp(8'h0C, 2'b00);
    regRd(2'd2, rd); check("R8 response first", rd, 32'h800C_C0C0);
    regRd(2'd2, rd); check("R8 timeout second", rd, 32'h830A_A0A0);

    // R10 write-one-to-clear per bit
    sendRsp(8'h77, 2'b00);
    regRd(2'd1, rd); check("R10 both set", rd, 32'd3);
    regWr(2'd1, 32'd1);
    regRd(2'd1, rd); check("R10 clear bit0 only", rd, 32'd2);
    regWr(2'd1, 32'd0);
    regRd(2'd1, rd); check("R10 zero write keeps", rd, 32'd2);
    regWr(2'd1, 32'd2);
    regRd(2'd1, rd); check("R10 clear bit1", rd, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule